// File: doc/BRIEF.md
# Warp Atomic Fetch-and-Add Unit

This block applies a whole warp's atomic add requests to a banked on-chip scratch memory that it owns. A request carries one word address, one 32-bit increment and one active bit per lane. Every active lane's increment is added to its target word exactly once. The value the word held just before that lane's own update is returned to the lane, as in a fetch-and-add. A typical use is histogram binning: the bin index is the address, and the increment is usually one.

The memory is split into banks. Each bank can perform one read-modify-write per cycle. Lanes whose words sit in different banks are served in the same cycle. Lanes that land in the same bank are served one per cycle, in ascending lane order. This holds whether those lanes share a word or hit different words of the bank. Several lanes on one word are never merged into a single access. A skewed request therefore costs as many cycles as the busiest bank has lanes.

Requests enter through a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle in which `done` pulses. The requester must hold its fields stable only up to that accepting edge. `done` is a plain one-cycle pulse that carries the cycle count. The per-lane returned values stay stable from `done` until the next request is accepted.

Top module: `smem_atomic_add`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, and every memory word holds 0.
- R2: A word address maps to bank = address bits [4:0] and row = address bits [6:5]. When all active lanes fall in distinct banks, the request completes with `done_cycles` = 1.
- R3: When all 32 lanes target the same word, 32 updates are applied one per cycle, and `done_cycles` = 32.
- R4: Among lanes in the same bank, updates are applied in ascending lane order. Each lane's `rsp_old` equals the word's value before the request plus the increments of lower-numbered active lanes to that word.
- R5: Lanes that target different words of one bank are also serialized. `done_cycles` equals the largest number of active lanes that map to any single bank.
- R6: A lane whose `req_mask` bit is 0 changes no memory word.
- R7: `req_ready` is low from the cycle after acceptance until the `done` cycle, in which it is high again. While `req_ready` is low, `req_valid` and the request fields have no effect.
- R8: `done` is high for exactly one cycle per accepted request. A request with no active lane completes with `done_cycles` = 0.
- R9: After any sequence of requests, each word equals its reset value plus the sum of all increments applied to it by active lanes, with no lost updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 224 | Lane word addresses, lane l at bits [7l+6:7l] |
| req_inc | input | 1024 | Lane increments, lane l at bits [32l+31:32l] |
| req_mask | input | 32 | Lane active bits |
| done | output | 1 | One-cycle completion pulse |
| done_cycles | output | 6 | Update cycles the request took |
| rsp_old | output | 1024 | Per-lane value before that lane's update, lane l at bits [32l+31:32l] |

## Verification
The hardest situation to reach is a request in which one bank receives several lanes that aim at different rows, while other banks receive several lanes that share a single word. The per-lane returned values then expose both the serialization and the lane ordering at the same time. The stimulus builds these cases from strided address patterns: stride 6 pairs lanes at different rows of one bank, and stride 32 drives every lane into bank 0 across all four rows. These are mixed with an all-lanes-one-word request carrying distinct increments. A second hard case is a request held on the inputs while the unit is busy. The bench keeps `req_valid` high with garbage fields throughout a busy window. It then proves through a final zero-increment sweep of all words that nothing extra was applied.

// File: rtl/smem_atomic_pkg.sv
package smem_atomic_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } unit_state_t;
endpackage

// File: rtl/smem_lane_pick.sv
// Per-bank arbiter: grants the lowest-numbered pending lane addressing this bank.
module smem_lane_pick #(
  parameter int LANES     = 32,
  parameter int BANK_BITS = 5,
  parameter int ROW_BITS  = 2,
  parameter int DW        = 32,
  parameter int BANK_ID   = 0,
  localparam int AW       = BANK_BITS + ROW_BITS
) (
  input  logic [LANES-1:0]    pending,
  input  logic [LANES*AW-1:0] addr_flat,
  input  logic [LANES*DW-1:0] inc_flat,
  output logic [LANES-1:0]    grant,
  output logic                any_grant,
  output logic [ROW_BITS-1:0] row_sel,
  output logic [DW-1:0]       inc_sel
);
  localparam logic [BANK_BITS-1:0] MY_BANK = BANK_ID[BANK_BITS-1:0];

  logic [LANES-1:0] hit;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      hit[l] = pending[l] && (addr_flat[l*AW +: BANK_BITS] == MY_BANK);
    end
  end

  assign grant     = hit & (~hit + 1'b1);
  assign any_grant = |hit;

  always_comb begin
    row_sel = '0;
    inc_sel = '0;
    for (int l = 0; l < LANES; l++) begin
      if (grant[l]) begin
        row_sel = row_sel | addr_flat[l*AW + BANK_BITS +: ROW_BITS];
        inc_sel = inc_sel | inc_flat[l*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/smem_rmw_bank.sv
// One bank: combinational read of the selected row, add-and-write on the edge.
module smem_rmw_bank #(
  parameter int ROW_BITS = 2,
  parameter int DW       = 32,
  localparam int ROWS    = 1 << ROW_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  logic [ROW_BITS-1:0] upd_row,
  input  logic [DW-1:0]       upd_inc,
  output logic [DW-1:0]       rd_word
);
  logic [DW-1:0] mem [ROWS];

  assign rd_word = mem[upd_row];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (upd_en) begin
      mem[upd_row] <= mem[upd_row] + upd_inc;
    end
  end
endmodule

// File: rtl/smem_atomic_add.sv
module smem_atomic_add
  import smem_atomic_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int BANK_BITS = 5,
  parameter int ROW_BITS  = 2,
  parameter int DW        = 32,
  localparam int BANKS    = 1 << BANK_BITS,
  localparam int AW       = BANK_BITS + ROW_BITS,
  localparam int CW       = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_inc,
  input  logic [LANES-1:0]    req_mask,
  output logic                done,
  output logic [CW-1:0]       done_cycles,
  output logic [LANES*DW-1:0] rsp_old
);
  unit_state_t         state_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*DW-1:0] inc_q;
  logic [LANES-1:0]    pending_q;
  logic [CW-1:0]       cnt_q;
  logic [LANES-1:0]    serve;
  logic [LANES-1:0]    grant_all [BANKS];
  logic [DW-1:0]       bank_rd   [BANKS];
  logic [DW-1:0]       old_q     [LANES];
  logic                busy;

  assign busy      = (state_q == ST_BUSY);
  assign req_ready = (state_q == ST_IDLE);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic                any_g;
    logic [ROW_BITS-1:0] row_s;
    logic [DW-1:0]       inc_s;

    smem_lane_pick #(
      .LANES(LANES), .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS),
      .DW(DW), .BANK_ID(b)
    ) u_pick (
      .pending  (pending_q),
      .addr_flat(addr_q),
      .inc_flat (inc_q),
      .grant    (grant_all[b]),
      .any_grant(any_g),
      .row_sel  (row_s),
      .inc_sel  (inc_s)
    );

    smem_rmw_bank #(.ROW_BITS(ROW_BITS), .DW(DW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_en (busy && any_g),
      .upd_row(row_s),
      .upd_inc(inc_s),
      .rd_word(bank_rd[b])
    );
  end

  always_comb begin
    serve = '0;
    for (int b = 0; b < BANKS; b++) serve = serve | grant_all[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      inc_q       <= '0;
      pending_q   <= '0;
      cnt_q       <= '0;
      done        <= 1'b0;
      done_cycles <= '0;
    end else begin
      done <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (req_valid) begin
          state_q   <= ST_BUSY;
          addr_q    <= req_addr;
          inc_q     <= req_inc;
          pending_q <= req_mask;
          cnt_q     <= '0;
        end
      end else if (pending_q == '0) begin
        state_q     <= ST_IDLE;
        done        <= 1'b1;
        done_cycles <= cnt_q;
      end else begin
        pending_q <= pending_q & ~serve;
        cnt_q     <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        old_q[l] <= '0;
      end else if (busy && serve[l]) begin
        old_q[l] <= bank_rd[addr_q[l*AW +: BANK_BITS]];
      end
    end
    assign rsp_old[l*DW +: DW] = old_q[l];
  end
endmodule

// File: rtl/smem_atomic_add_chk.sv
module smem_atomic_add_chk #(
  parameter int LANES = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic [CW-1:0] done_cycles
);
  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_ready_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_instant_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !done);

  assert_cycle_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_cycles <= CW'(LANES)));
endmodule

bind smem_atomic_add smem_atomic_add_chk #(.LANES(LANES), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .done       (done),
  .done_cycles(done_cycles)
);

// File: tb/smem_atomic_add_bench.sv
module smem_atomic_add_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 32;
  localparam int AW = 7;
  localparam int DW = 32;
  localparam int NW = 128;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [L*AW-1:0] req_addr = '0;
  logic [L*DW-1:0] req_inc = '0;
  logic [L-1:0]    req_mask = '0;
  logic            done;
  logic [5:0]      done_cycles;
  logic [L*DW-1:0] rsp_old;

  int tests = 0;
  int fails = 0;

  logic [AW-1:0] ta [L];
  logic [DW-1:0] ti [L];
  logic [L-1:0]  tm;
  logic [DW-1:0] model [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  smem_atomic_add u_smem_atomic_add (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_inc(req_inc), .req_mask(req_mask),
    .done(done), .done_cycles(done_cycles), .rsp_old(rsp_old)
  );

  task automatic check(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Issues the request held in ta/ti/tm; optionally keeps valid high with junk while busy.
  task automatic run_op(input string req, input bit hold_junk);
    logic [DW-1:0] exp_old [L];
    int cnt [L];
    int exp_cyc = 0;
    int guard = 0;
    int bad_old = -1;
    bit ready_bad = 0;
    for (int b = 0; b < L; b++) cnt[b] = 0;
    for (int l = 0; l < L; l++) begin
      exp_old[l] = 32'hX;
      if (tm[l]) begin
        exp_old[l] = model[ta[l]];
        model[ta[l]] = model[ta[l]] + ti[l];
        cnt[ta[l][4:0]]++;
        if (cnt[ta[l][4:0]] > exp_cyc) exp_cyc = cnt[ta[l][4:0]];
      end
    end
    @(negedge clk);
    while (!req_ready && guard < 400) begin @(negedge clk); guard++; end
    for (int l = 0; l < L; l++) begin
      req_addr[l*AW +: AW] = ta[l];
      req_inc[l*DW +: DW]  = ti[l];
    end
    req_mask  = tm;
    req_valid = 1'b1;
    @(negedge clk);
    if (hold_junk) begin
      req_mask = '1;
      for (int l = 0; l < L; l++) req_inc[l*DW +: DW] = 32'h1000_0000;
    end else begin
      req_valid = 1'b0;
    end
    while (!done && guard < 400) begin
      if (req_ready) ready_bad = 1;
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b0;
    check("R7", "ready low while busy", {31'b0, ready_bad}, 32'd0);
    check(req, "done seen", {31'b0, done}, 32'd1);
    check("R7", "ready at done", {31'b0, req_ready}, 32'd1);
    check(req, "done_cycles", {26'b0, done_cycles}, exp_cyc);
    for (int l = 0; l < L; l++)
      if (tm[l] && bad_old < 0 && rsp_old[l*DW +: DW] !== exp_old[l]) bad_old = l;
    if (bad_old >= 0)
      check(req, $sformatf("rsp_old lane %0d", bad_old),
            rsp_old[bad_old*DW +: DW], exp_old[bad_old]);
    else
      check(req, "rsp_old all lanes", 32'd0, 32'd0);
    @(negedge clk);
    check("R8", "done one cycle", {31'b0, done}, 32'd0);
  endtask

  // Reads every word with zero increments and compares with the model.
  task automatic sweep(input string req);
    logic [DW-1:0] snap [NW];
    for (int w = 0; w < NW; w++) snap[w] = model[w];
    for (int p = 0; p < NW / L; p++) begin
      for (int l = 0; l < L; l++) begin
        ta[l] = AW'(p * L + l);
        ti[l] = '0;
      end
      tm = '1;
      run_op(req, 1'b0);
    end
    for (int w = 0; w < NW; w++) check(req, $sformatf("word %0d", w), model[w], snap[w]);
  endtask

  task automatic t_reset;
    check("R1", "ready after reset", {31'b0, req_ready}, 32'd1);
    check("R1", "done after reset", {31'b0, done}, 32'd0);
    sweep("R1");
  endtask

  task automatic t_distinct;
    for (int l = 0; l < L; l++) begin ta[l] = AW'(l); ti[l] = 32'(l + 1); end
    tm = '1;
    run_op("R2", 1'b0);
    for (int l = 0; l < L; l++) begin
      ta[l] = AW'(((l * 7) % 32) + 32 * (l % 4));
      ti[l] = 32'(100 + l);
    end
    run_op("R2", 1'b0);
  endtask

  task automatic t_same_word;
    for (int l = 0; l < L; l++) begin ta[l] = AW'(5); ti[l] = 32'(l * 3 + 1); end
    tm = '1;
    run_op("R3", 1'b0);
    for (int l = 0; l < L; l++) begin ta[l] = AW'(69); ti[l] = 32'(1 << (l % 8)); end
    run_op("R4", 1'b0);
  endtask

  task automatic t_bank_rows;
    for (int l = 0; l < L; l++) begin ta[l] = AW'((l * 6) % NW); ti[l] = 32'(7 + l); end
    tm = '1;
    run_op("R5", 1'b0);
    for (int l = 0; l < L; l++) begin ta[l] = AW'((l * 32) % NW); ti[l] = 32'(l); end
    run_op("R5", 1'b0);
    for (int l = 0; l < L; l++) begin ta[l] = AW'((l % 3) * 32 + (l % 4)); ti[l] = 32'(2); end
    run_op("R4", 1'b0);
  endtask

  task automatic t_mask;
    for (int l = 0; l < L; l++) begin ta[l] = AW'(l + 32); ti[l] = 32'hAB; end
    tm = 32'h5555_0F0F;
    run_op("R6", 1'b0);
    tm = '0;
    run_op("R8", 1'b0);
    sweep("R6");
  endtask

  task automatic t_held_valid;
    for (int l = 0; l < L; l++) begin ta[l] = AW'(9); ti[l] = 32'd1; end
    tm = '1;
    run_op("R7", 1'b1);
    sweep("R7");
  endtask

  initial begin
    for (int w = 0; w < NW; w++) model[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_distinct();
    t_same_word();
    t_bank_rows();
    t_mask();
    t_held_valid();
    sweep("R9");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule